// File: doc/BRIEF.md
# DRAM Controller Boot Handshake Register Stub

This block stands in for the software-facing side of a DRAM controller while firmware boots. It holds three 32-bit registers behind a simple word-wide register bus: a controller command register, an impedance-calibration command register and an impedance-calibration status register. Firmware that starts DRAM initialisation or data training and then polls for the start bit to drop sees the operation finish at once. Firmware that starts impedance calibration and then waits on a done flag also sees it finish at once. No DRAM timing, PHY, refresh or memory array exists behind the registers.

The bus carries a byte offset, separate read and write strobes, four byte enables and write data. A write lands on the clock edge where the write strobe is high. Read data is registered and comes back one cycle after the read strobe, marked by a valid pulse. An access the block cannot honour raises a one-cycle error pulse in that same following cycle and changes nothing. Such an access is one that is partial, misaligned, aimed at an offset with no register, or beyond the window.

Top module: `dram_boot_regs`

## Requirements
- R1: After reset the command register (offset 0x000) reads 0x80020000, the calibration command register (offset 0x0A8) reads 0x07B00000 and the calibration status register (offset 0x0B0) reads 0x80000000.
- R2: A write to the command register stores bit 31 (init start) as 0 whatever value was written to it.
- R3: A write to the command register stores bit 30 (training start) as 0, and stores bits 29..0 exactly as written.
- R4: A write of any value to the calibration command register stores that value and, on the same edge, sets bit 31 (calibration done) of the calibration status register while leaving its bits 30..0 unchanged.
- R5: A write to the calibration status register stores the written value in full.
- R6: An access whose byte enables are not all four set (bus_be other than 4'hF), or whose offset has bit 1 or bit 0 set, changes no register and reads back zero.
- R7: An access to an offset in the window with no register (including 0x2E4 up to the window end), or at or beyond WINDOW_BYTES, changes no register and reads back zero.
- R8: bus_rvalid is high in exactly the cycle after a cycle with bus_rd high, and bus_rdata holds the read result in that cycle and zero in every other cycle.
- R9: bus_err is high for one cycle in the cycle after each access covered by R6 or R7, and low after every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, zero outside a read response |
| bus_rvalid | output | 1 | High in the cycle that carries read data |
| bus_err | output | 1 | One-cycle pulse after a rejected access |

## Verification
The embedded properties check on every cycle that a read strobe is answered by a valid pulse, that neither start bit can survive a command write, that a calibration command write always leaves the done flag set, and that a rejected write leaves all three registers untouched with zero read data on any error response. Whether the low command bits, the status bits below the done flag, and the reset values hold exactly the right numbers can only be shown by the bench. It drives directed and randomised access sequences against a behavioural register model, and mixes partial, misaligned, empty and out-of-window offsets with legal ones.

// File: rtl/dram_boot_regs.sv
module dram_boot_regs #(
  parameter int          ADDR_W       = 16,
  parameter int          WINDOW_BYTES = 1024,
  parameter logic [31:0] OFF_CMD      = 32'h0000_0000,
  parameter logic [31:0] OFF_CAL_CMD  = 32'h0000_00A8,
  parameter logic [31:0] OFF_CAL_STAT = 32'h0000_00B0,
  parameter logic [31:0] RST_CMD      = 32'h8002_0000,
  parameter logic [31:0] RST_CAL_CMD  = 32'h07B0_0000,
  parameter logic [31:0] RST_CAL_STAT = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err
);

  localparam logic [ADDR_W:0]   WIN_LIMIT  = (ADDR_W+1)'(WINDOW_BYTES);
  localparam logic [ADDR_W-1:0] A_CMD      = OFF_CMD[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CAL_CMD  = OFF_CAL_CMD[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CAL_STAT = OFF_CAL_STAT[ADDR_W-1:0];
  localparam logic [31:0]       START_MASK = 32'hC000_0000;
  localparam logic [31:0]       DONE_BIT   = 32'h8000_0000;

  logic [31:0] cmd_q, cal_cmd_q, cal_stat_q;
  logic        word_ok, hit_cmd, hit_cal_cmd, hit_cal_stat, hit_any, access;
  logic [31:0] rd_mux;

  assign word_ok      = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00)
                        && ({1'b0, bus_addr} < WIN_LIMIT);
  assign hit_cmd      = word_ok && (bus_addr == A_CMD);
  assign hit_cal_cmd  = word_ok && (bus_addr == A_CAL_CMD);
  assign hit_cal_stat = word_ok && (bus_addr == A_CAL_STAT);
  assign hit_any      = hit_cmd || hit_cal_cmd || hit_cal_stat;
  assign access       = bus_rd || bus_wr;

  always_comb begin
    rd_mux = '0;
    if (hit_cmd)      rd_mux = cmd_q;
    if (hit_cal_cmd)  rd_mux = cal_cmd_q;
    if (hit_cal_stat) rd_mux = cal_stat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q      <= RST_CMD;
      cal_cmd_q  <= RST_CAL_CMD;
      cal_stat_q <= RST_CAL_STAT;
    end else if (bus_wr) begin
      if (hit_cmd)      cmd_q      <= bus_wdata & ~START_MASK;
      if (hit_cal_cmd) begin
        cal_cmd_q  <= bus_wdata;
        cal_stat_q <= cal_stat_q | DONE_BIT;
      end
      if (hit_cal_stat) cal_stat_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rdata  <= bus_rd ? rd_mux : '0;
      bus_rvalid <= bus_rd;
      bus_err    <= access && !hit_any;
    end
  end

  a_r8_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  a_r8_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> bus_rdata == 32'h0);

  a_r2_init_start_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cmd) |=> !cmd_q[31]);

  a_r3_training_start_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cmd) |=> !cmd_q[30]);

  a_r4_cal_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cal_cmd) |=> cal_stat_q[31]);

  a_r7_rejected_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_any) |=> ($stable(cmd_q) && $stable(cal_cmd_q) && $stable(cal_stat_q)));

  a_r6_error_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && bus_rvalid) |-> bus_rdata == 32'h0);

  a_r9_error_single: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> !bus_err);

endmodule

// File: tb/dram_boot_regs_tb.sv
module dram_boot_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R8";
  string cyc_tag = "R8";

  always #4 clk = ~clk;

  dram_boot_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err)
  );

  logic [31:0] m_cmd, m_cal, m_stat;
  logic [31:0] e_data;
  logic        e_valid, e_err;

  function automatic bit legal(input logic [15:0] a, input logic [3:0] be);
    return be == 4'hF && a < 16'h0400 && (a == 16'h0000 || a == 16'h00A8 || a == 16'h00B0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmd = 32'h8002_0000; m_cal = 32'h07B0_0000; m_stat = 32'h8000_0000;
      e_data = 0; e_valid = 0; e_err = 0;
    end else begin
      cyc_tag = cur_tag;
      e_valid = bus_rd;
      e_err   = (bus_rd || bus_wr) && !legal(bus_addr, bus_be);
      e_data  = 0;
      if (bus_rd && legal(bus_addr, bus_be))
        case (bus_addr)
          16'h0000: e_data = m_cmd;
          16'h00A8: e_data = m_cal;
          default:  e_data = m_stat;
        endcase
      if (bus_wr && legal(bus_addr, bus_be))
        case (bus_addr)
          16'h0000: begin m_cmd = bus_wdata; m_cmd[31] = 1'b0; m_cmd[30] = 1'b0; end
          16'h00A8: begin m_cal = bus_wdata; m_stat[31] = 1'b1; end
          default:  m_stat = bus_wdata;
        endcase
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (bus_rvalid !== e_valid || bus_rdata !== e_data || bus_err !== e_err) begin
        errors++;
        $display("FAIL %s cycle %0d: valid/data/err %b/%h/%b expected %b/%h/%b",
                 cyc_tag, cycles, bus_rvalid, bus_rdata, bus_err, e_valid, e_data, e_err);
      end
    end
  end

  task automatic idle();
    bus_rd = 0; bus_wr = 0; bus_be = 4'hF;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d,
                    input logic [3:0] be, input string tag);
    @(negedge clk);
    cur_tag = tag; bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1; bus_rd = 0;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_expect(input logic [15:0] a, input logic [3:0] be,
                           input logic [31:0] exp, input logic exp_err, input string tag);
    @(negedge clk);
    cur_tag = tag; bus_addr = a; bus_be = be; bus_rd = 1; bus_wr = 0;
    @(negedge clk);
    idle();
    checks++;
    if (bus_rvalid !== 1'b1 || bus_rdata !== exp || bus_err !== exp_err) begin
      errors++;
      $display("FAIL %s read %h: valid/data/err %b/%h/%b expected 1/%h/%b",
               tag, a, bus_rvalid, bus_rdata, bus_err, exp, exp_err);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (bus_rvalid !== 0 || bus_err !== 0 || bus_rdata !== 0) begin
      errors++;
      $display("FAIL R1 outputs in reset %b/%b/%h expected 0/0/0", bus_rvalid, bus_err, bus_rdata);
    end
    rst_n = 1;
    rd_expect(16'h0000, 4'hF, 32'h8002_0000, 0, "R1");
    rd_expect(16'h00A8, 4'hF, 32'h07B0_0000, 0, "R1");
    rd_expect(16'h00B0, 4'hF, 32'h8000_0000, 0, "R1");

    wr(16'h0000, 32'hC000_0005, 4'hF, "R2");
    rd_expect(16'h0000, 4'hF, 32'h0000_0005, 0, "R2");
    wr(16'h0000, 32'h8000_0000, 4'hF, "R2");
    rd_expect(16'h0000, 4'hF, 32'h0000_0000, 0, "R2");
    wr(16'h0000, 32'h4000_1234, 4'hF, "R3");
    rd_expect(16'h0000, 4'hF, 32'h0000_1234, 0, "R3");
    wr(16'h0000, 32'h3FFF_FFFF, 4'hF, "R3");
    rd_expect(16'h0000, 4'hF, 32'h3FFF_FFFF, 0, "R3");

    wr(16'h00B0, 32'h0000_0000, 4'hF, "R5");
    rd_expect(16'h00B0, 4'hF, 32'h0000_0000, 0, "R5");
    wr(16'h00A8, 32'hDEAD_BEEF, 4'hF, "R4");
    rd_expect(16'h00A8, 4'hF, 32'hDEAD_BEEF, 0, "R4");
    rd_expect(16'h00B0, 4'hF, 32'h8000_0000, 0, "R4");
    wr(16'h00B0, 32'h0000_00A5, 4'hF, "R5");
    rd_expect(16'h00B0, 4'hF, 32'h0000_00A5, 0, "R5");
    wr(16'h00A8, 32'h0000_0000, 4'hF, "R4");
    rd_expect(16'h00B0, 4'hF, 32'h8000_00A5, 0, "R4");

    wr(16'h0000, 32'h0000_0FFF, 4'h3, "R6");
    rd_expect(16'h0000, 4'hF, 32'h3FFF_FFFF, 0, "R6");
    wr(16'h0002, 32'h0000_0000, 4'hF, "R6");
    rd_expect(16'h0000, 4'hF, 32'h3FFF_FFFF, 0, "R6");
    rd_expect(16'h00A8, 4'h1, 32'h0, 1, "R6");
    rd_expect(16'h00B1, 4'hF, 32'h0, 1, "R6");

    wr(16'h0004, 32'hFFFF_FFFF, 4'hF, "R7");
    rd_expect(16'h0004, 4'hF, 32'h0, 1, "R7");
    rd_expect(16'h02E4, 4'hF, 32'h0, 1, "R7");
    rd_expect(16'h03FC, 4'hF, 32'h0, 1, "R7");
    wr(16'h0400, 32'h1111_1111, 4'hF, "R7");
    rd_expect(16'h0400, 4'hF, 32'h0, 1, "R7");
    rd_expect(16'h00A8, 4'hF, 32'h0000_0000, 0, "R7");

    @(negedge clk);
    cur_tag = "R8"; bus_rd = 1; bus_addr = 16'h0000;
    @(negedge clk); bus_addr = 16'h00B0;
    @(negedge clk); bus_addr = 16'h00AC;
    @(negedge clk); idle();

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [3:0]  be;
      logic [31:0] pick;
      @(negedge clk);
      pick = $urandom;
      case (pick[2:0])
        3'd0, 3'd1: a = 16'h0000;
        3'd2:       a = 16'h00A8;
        3'd3:       a = 16'h00B0;
        3'd4:       a = 16'h02E4;
        3'd5:       a = 16'h0401;
        3'd6:       a = 16'h00AC;
        default:    a = {6'b0, pick[9:0]};
      endcase
      be = pick[5:3] == 3'd0 ? pick[9:6] : 4'hF;
      cur_tag = pick[13] ? "R9" : "R8";
      bus_addr = a; bus_be = be; bus_wdata = $urandom;
      bus_rd = pick[11]; bus_wr = pick[12] & ~pick[11];
    end
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule